// File: doc/BRIEF.md
# Processor Bus Error Logger

This block sits beside a processor bus slave port and the memory address decoder. For every transfer it looks for three fault classes. The first is a bad memory select: an address that no decoder range claims, or a write to ROM/peripheral space while that space is set to read-only. The second is a flash write to a bank that has no flash-write permission. The third is an odd-parity failure on the address bus. A faulting read still completes, with all-ones data. A faulting write still completes, but the memory never sees its write strobe.

The first enabled fault is recorded in a sticky status register. A memory select or flash fault also freezes the transfer's address and attribute byte in capture registers. Later faults go unrecorded until software clears every status bit by writing ones to them. An optional active-low machine-check pulse reports each recorded fault. A small register port gives access to the enables, status, options and captures.

Register map (`reg_addr`): 0 = enables, 1 = status, 2 = options, 3 = captured address, 4 = captured attributes in bits 7:0. Any other address reads 0. The enable and status registers share one bit layout: bit 0 memory select, bit 1 flash write, bit 2 address parity. Option bit 0 allows the machine check. Option bit 1 makes ROM/peripheral space read-only.

Top module: `bus_err_logger`

## Requirements
- R1: A read (`tr_write`=0, `tr_aonly`=0) with a memory select fault while enable bit 0 is set returns `rd_data` of all ones with `tr_ack` high in the cycle after the request. Every other read returns the `mem_rdata` sampled with the request, and every request gets `tr_ack` one cycle later.
- R2: During a write request, `mem_wr_en` is low when an enabled memory select fault (enable bit 0) or an enabled flash fault (enable bit 1) is present. Otherwise it is high for every write request. `mem_rd_en` is high for a read request that has no enabled memory select fault.
- R3: A memory select fault is either `sel_valid`=0 on a data transfer, or a write with `sel_rom`=1 while option bit 1 is set. Address-only transfers never raise a memory select fault or a flash fault.
- R4: A flash fault is a write with `sel_valid`=1, `sel_flash`=1 and `flash_wr_ok`=0. It also counts as a memory select fault, so with both enables set, status bits 0 and 1 are both recorded.
- R5: Each status bit is set only when its own enable bit is set.
- R6: When a memory select or flash fault is recorded, `tr_addr` and `tr_attr` of that transfer are copied into the capture registers.
- R7: The address bits and `tr_apar` together must hold an odd number of ones. A failure with enable bit 2 set sets status bit 2 and leaves the capture registers unchanged, while the transfer completes with normal data and strobes.
- R8: While any status bit is set, no new fault is recorded. Status, captures and the machine check are all unaffected.
- R9: Writing register 1 clears each status bit written as 1 and keeps each bit written as 0. If a clear that empties the status arrives in the same cycle as a new fault, the new fault is recorded.
- R10: With option bit 0 set, a recorded fault drives `mchk_n` low for exactly `MCHK_CYC` (2) cycles, starting the cycle after the request. With option bit 0 clear, `mchk_n` stays high.
- R11: After reset, the enables, status, options and captures are zero, and `mchk_n` and `tr_ack` are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tr_valid | input | 1 | Transfer request, one cycle |
| tr_write | input | 1 | 1 = write, 0 = read |
| tr_aonly | input | 1 | Address-only transfer |
| tr_addr | input | AW | Transfer address |
| tr_apar | input | 1 | Address parity bit (odd) |
| tr_attr | input | TW | Transfer attributes |
| sel_valid | input | 1 | Decoder claims the address |
| sel_rom | input | 1 | Address is in ROM/peripheral space |
| sel_flash | input | 1 | Address is in a flash bank |
| flash_wr_ok | input | 1 | Bank permits flash writes |
| mem_rdata | input | DW | Read data from memory |
| mem_wr_en | output | 1 | Write strobe passed to memory |
| mem_rd_en | output | 1 | Read strobe passed to memory |
| tr_ack | output | 1 | Transfer acknowledge |
| rd_data | output | DW | Read data to processor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mchk_n | output | 1 | Machine check, active low |

## Verification
The status bits gate all later recording. A status bit that is wrongly set or wrongly cleared therefore shows at register 1 right after the transfer's clock edge. It also changes every later capture and machine-check decision, so the bench compares status and captures after every transfer. A wrong pulse counter shows on `mchk_n` within two cycles, and each transfer watches three cycles of it. A wrong fault decode shows in the same cycle as a misplaced write strobe, and one cycle later as wrong read data.

// File: rtl/bus_err_logger.sv
module bus_err_logger #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 8,
  parameter int MCHK_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tr_valid,
  input  logic          tr_write,
  input  logic          tr_aonly,
  input  logic [AW-1:0] tr_addr,
  input  logic          tr_apar,
  input  logic [TW-1:0] tr_attr,
  input  logic          sel_valid,
  input  logic          sel_rom,
  input  logic          sel_flash,
  input  logic          flash_wr_ok,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr_en,
  output logic          mem_rd_en,
  output logic          tr_ack,
  output logic [DW-1:0] rd_data,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mchk_n
);
  localparam int CW = $clog2(MCHK_CYC + 1);

  logic [2:0]    en, sts;
  logic [1:0]    opt;
  logic [AW-1:0] cap_addr;
  logic [TW-1:0] cap_attr;
  logic [CW-1:0] cnt;

  wire data_x = tr_valid & ~tr_aonly;
  wire wr_x   = data_x & tr_write;
  wire rd_x   = data_x & ~tr_write;
  wire fl_hit = wr_x & sel_valid & sel_flash & ~flash_wr_ok;
  wire ms_hit = data_x & (~sel_valid | (tr_write & sel_rom & opt[1]) | fl_hit);
  wire pa_hit = tr_valid & ~(^{tr_addr, tr_apar});

  wire [2:0] det = en & {pa_hit, fl_hit, ms_hit};
  wire [2:0] clr = (reg_wr && reg_addr == 3'd1) ? reg_wdata[2:0] : 3'b000;
  wire [2:0] kept = sts & ~clr;
  wire       log_ok = ~|kept;
  wire       new_err = log_ok & |det;
  wire       unused_ok = &{1'b0, reg_wdata[31:3]};

  assign mem_wr_en = wr_x & ~det[0] & ~det[1];
  assign mem_rd_en = rd_x & ~det[0];
  assign mchk_n    = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      opt      <= '0;
      sts      <= '0;
      cap_addr <= '0;
      cap_attr <= '0;
      cnt      <= '0;
      tr_ack   <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd0) en  <= reg_wdata[2:0];
      if (reg_wr && reg_addr == 3'd2) opt <= reg_wdata[1:0];
      sts <= kept | (log_ok ? det : 3'b000);
      if (log_ok && (det[0] || det[1])) begin
        cap_addr <= tr_addr;
        cap_attr <= tr_attr;
      end
      if (new_err && opt[0]) cnt <= CW'(MCHK_CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
      tr_ack  <= tr_valid;
      rd_data <= (rd_x && det[0]) ? '1 : mem_rdata;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {29'd0, en};
      3'd1:    reg_rdata = {29'd0, sts};
      3'd2:    reg_rdata = {30'd0, opt};
      3'd3:    reg_rdata = 32'(cap_addr);
      3'd4:    reg_rdata = 32'(cap_attr);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module bus_err_logger_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tr_valid,
  input logic          tr_write,
  input logic          tr_aonly,
  input logic          sel_valid,
  input logic          tr_ack,
  input logic [DW-1:0] rd_data,
  input logic          mem_wr_en,
  input logic          mchk_n,
  input logic [2:0]    en,
  input logic [2:0]    sts,
  input logic [AW-1:0] cap_addr,
  input logic [TW-1:0] cap_attr,
  input logic          reg_wr,
  input logic [2:0]    reg_addr
);
  a_r1_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_write && !tr_aonly && !sel_valid && en[0]) |=> (tr_ack && rd_data == '1));

  a_r2_drop_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_write && !tr_aonly && !sel_valid && en[0]) |-> !mem_wr_en);

  a_r2_strobe_qual: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (tr_valid && tr_write));

  a_r8_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sts) && !(reg_wr && reg_addr == 3'd1)) |=> ($stable(cap_addr) && $stable(cap_attr)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd1) |=> ((sts & $past(sts)) == $past(sts)));

  a_r10_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mchk_n) |=> !mchk_n);
endmodule

bind bus_err_logger bus_err_logger_chk #(.AW(AW), .DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_write(tr_write),
  .tr_aonly(tr_aonly), .sel_valid(sel_valid), .tr_ack(tr_ack),
  .rd_data(rd_data), .mem_wr_en(mem_wr_en), .mchk_n(mchk_n), .en(en),
  .sts(sts), .cap_addr(cap_addr), .cap_attr(cap_attr), .reg_wr(reg_wr),
  .reg_addr(reg_addr)
);

// File: tb/bus_err_logger_test.sv
module bus_err_logger_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tr_valid = 0, tr_write = 0, tr_aonly = 0, tr_apar = 0;
  logic [31:0] tr_addr = 0, mem_rdata = 0, reg_wdata = 0, reg_rdata, rd_data;
  logic [7:0]  tr_attr = 0;
  logic        sel_valid = 1, sel_rom = 0, sel_flash = 0, flash_wr_ok = 0;
  logic        mem_wr_en, mem_rd_en, tr_ack, mchk_n, reg_wr = 0;
  logic [2:0]  reg_addr = 0;

  int checks = 0, errors = 0;
  logic [2:0]  m_en = 0, m_sts = 0;
  logic [1:0]  m_opt = 0;
  logic [31:0] m_ca = 0;
  logic [7:0]  m_ct = 0;

  always #10 clk = ~clk;

  bus_err_logger uut (.*);

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic regw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) m_en = d[2:0];
    if (a == 1) m_sts = m_sts & ~d[2:0];
    if (a == 2) m_opt = d[1:0];
  endtask

  function automatic logic [2:0] faults(input bit w, input bit ao, input bit sv, input bit sr,
                                        input bit sf, input bit fo, input bit pok);
    bit data = !ao;
    bit fl = data && w && sv && sf && !fo;
    bit ms = data && (!sv || (w && sr && m_opt[1]) || fl);
    return {!pok, fl, ms};
  endfunction

  task automatic check_regs(input string tag);
    logic [31:0] v;
    rdreg(3'd1, v); chk(v == {29'd0, m_sts}, {tag, " status"}, v, {29'd0, m_sts});
    rdreg(3'd3, v); chk(v == m_ca, {tag, " R6 cap addr"}, v, m_ca);
    rdreg(3'd4, v); chk(v == {24'd0, m_ct}, {tag, " R6 cap attr"}, v, {24'd0, m_ct});
  endtask

  task automatic xfer(input string tag, input bit w, input bit ao, input logic [31:0] a,
                      input bit pok, input logic [7:0] t, input bit sv, input bit sr,
                      input bit sf, input bit fo);
    logic [2:0] d;
    logic [31:0] md, exp_rd;
    bit exp_we, exp_m, ok;
    d = faults(w, ao, sv, sr, sf, fo, pok) & m_en;
    md = $urandom;
    @(negedge clk);
    tr_valid = 1; tr_write = w; tr_aonly = ao; tr_addr = a; tr_attr = t;
    tr_apar = (^a) ^ 1'b1 ^ !pok;
    sel_valid = sv; sel_rom = sr; sel_flash = sf; flash_wr_ok = fo; mem_rdata = md;
    exp_we = w && !ao && !d[0] && !d[1];
    #1 chk(mem_wr_en == exp_we, {tag, " R2 wr strobe"}, mem_wr_en, exp_we);
    chk(mem_rd_en == (!w && !ao && !d[0]), {tag, " R2 rd strobe"}, mem_rd_en, !w && !ao && !d[0]);
    ok = (m_sts == 0);
    exp_m = ok && (d != 0) && m_opt[0];
    if (ok) begin
      m_sts = m_sts | d;
      if (d[0] || d[1]) begin m_ca = a; m_ct = t; end
    end
    exp_rd = (!w && !ao && d[0]) ? 32'hFFFF_FFFF : md;
    @(negedge clk);
    tr_valid = 0;
    chk(tr_ack == 1'b1, {tag, " R1 ack"}, tr_ack, 1);
    if (!w && !ao) chk(rd_data == exp_rd, {tag, " R1 rd data"}, rd_data, exp_rd);
    chk(mchk_n == !exp_m, {tag, " R10 mchk c0"}, mchk_n, !exp_m);
    check_regs(tag);
    @(negedge clk);
    chk(mchk_n == !exp_m, {tag, " R10 mchk c1"}, mchk_n, !exp_m);
    @(negedge clk);
    chk(mchk_n == 1'b1, {tag, " R10 mchk release"}, mchk_n, 1);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    #35 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(mchk_n == 1 && tr_ack == 0, "R11 outputs", {mchk_n, tr_ack}, 2'b10);
    rdreg(3'd0, v); chk(v == 0, "R11 enables", v, 0);
    rdreg(3'd2, v); chk(v == 0, "R11 options", v, 0);
    check_regs("R11");

    regw(0, 7); regw(2, 3);
    xfer("R1 clean read", 0, 0, 32'h1000_0040, 1, 8'h11, 1, 0, 0, 0);
    xfer("R1 R3 out of range read", 0, 0, 32'h8765_4320, 1, 8'h5A, 0, 0, 0, 0);
    xfer("R8 blocked write", 1, 0, 32'h0000_1234, 1, 8'h22, 0, 0, 0, 0);
    regw(1, 0); check_regs("R9 write zero keeps");
    regw(1, 1); check_regs("R9 write one clears");
    xfer("R3 rom write ro", 1, 0, 32'hFFF0_0010, 1, 8'h33, 1, 1, 0, 0);
    regw(1, 7); regw(2, 1);
    xfer("R3 rom write rw", 1, 0, 32'hFFF0_0014, 1, 8'h34, 1, 1, 0, 0);
    xfer("R3 address only", 0, 1, 32'h9000_0000, 1, 8'h35, 0, 0, 0, 0);
    xfer("R4 flash both", 1, 0, 32'h0200_0000, 1, 8'h44, 1, 0, 1, 0);
    regw(1, 7); regw(0, 6);
    xfer("R4 R5 flash only", 1, 0, 32'h0200_0100, 1, 8'h45, 1, 0, 1, 0);
    regw(1, 7); regw(0, 7);
    xfer("R7 parity", 0, 0, 32'h0000_0800, 0, 8'h66, 1, 0, 0, 0);
    regw(1, 4); regw(0, 0);
    xfer("R5 disabled", 0, 0, 32'hDEAD_0000, 0, 8'h77, 0, 0, 0, 0);
    regw(0, 7); regw(2, 0);
    xfer("R10 no mchk", 0, 0, 32'hBAD0_0000, 1, 8'h78, 0, 0, 0, 0);

    // R9 clear and new fault in the same cycle
    @(negedge clk);
    reg_wr = 1; reg_addr = 1; reg_wdata = 1;
    tr_valid = 1; tr_write = 0; tr_aonly = 0; tr_addr = 32'hCAFE_0000;
    tr_apar = (^tr_addr) ^ 1'b1; tr_attr = 8'h99; sel_valid = 0;
    @(negedge clk);
    reg_wr = 0; tr_valid = 0;
    m_sts = 1; m_ca = 32'hCAFE_0000; m_ct = 8'h99;
    check_regs("R9 same cycle");
    regw(1, 7); regw(2, 3);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 0) regw(0, {29'd0, r[6:4]});
      if (r[7:4] == 1) regw(2, {30'd0, r[9:8]});
      if (r[10]) regw(1, {29'd0, r[13:11]});
      xfer("rand", r[14], r[17:15] == 0, $urandom, r[20:18] != 0, r[28:21],
           r[24:22] != 0, r[25], r[26], r[27]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule